// File: doc/BRIEF.md
# Software Interrupt Source Dispatcher

This block holds the delivery state of software-raised interrupts in a multi-processor system. For every pair of interrupt number (0 to NSGI-1) and receiving processor, it keeps two things: a bitmap with one bit per requesting processor, and a pending flag. Processors change that state through a small register write port. A word command at address 0xF00 fans one interrupt out to a set of receivers. Byte writes in two 16-byte windows set or clear source bits directly. Each write carries the ID of the processor that issued it.

A receiving processor takes an interrupt through the acknowledge port. One cycle later the block reports the lowest-numbered requester still recorded for that pair, and removes that requester's bit. The pending flag of a pair stays up while any requester remains recorded. The flags of all pairs leave the block as one flat vector, to be used by a priority stage outside this block.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst_n` is low and after it rises, every pending flag is 0, every bitmap is empty, `ack_done` is 0 and `rd_data` is 0.
- R2: A write to address 0xF00 is a send command. `wr_data[9:0]` is the interrupt number, `wr_data[23:16]` the receiver list and `wr_data[25:24]` the filter. With filter 0, the writer's bit is set in the bitmap of each listed receiver, and that pair becomes pending at the next clock edge.
- R3: Filter 1 sends to every processor except the writer. Filter 2 sends only to the writer. Filter 3 is treated as sending to every processor.
- R4: These writes change nothing: a send command whose interrupt number is NSGI or more, and any write whose `wr_cpu` is NCPU or more. Receiver list bits at positions NCPU and above are ignored.
- R5: A byte write to 0xF20+n ORs `wr_data[NCPU-1:0]` into the writer's bitmap for interrupt n. It marks that pair pending, even when the data is zero.
- R6: A byte write to 0xF10+n clears the bits of `wr_data[NCPU-1:0]` from the writer's bitmap for interrupt n. The pending flag drops if the bitmap is then empty, and otherwise stays.
- R7: A read request at 0xF10+n or 0xF20+n returns the requester's bitmap for interrupt n, zero-extended, on `rd_data` one cycle later. Any other address, or a requester ID of NCPU or more, returns 0.
- R8: `ack_req` from a processor below NCPU produces `ack_done` for exactly one cycle, one cycle later. `ack_found`=1 and `ack_src` hold the lowest set bit of the old bitmap, and that bit is cleared. An empty bitmap gives `ack_found`=0 and `ack_src`=0. An acknowledge from an ID of NCPU or more produces no response.
- R9: An acknowledge clears the pair's pending flag only when its bitmap is empty afterwards. This includes a pair that was pending with an empty bitmap.
- R10: An acknowledge and a write in the same cycle both take effect. The source is taken from the state before that cycle. All clears are applied before all sets, and a set makes the pair pending.
- R11: The flag of receiver t for interrupt s is `pend[t*NSGI+s]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | 3 | ID of the writing processor |
| wr_addr | input | 12 | Register byte address |
| wr_data | input | 32 | Write data (byte writes use bits 7:0) |
| rd_en | input | 1 | Bitmap read request |
| rd_cpu | input | 3 | ID of the reading processor |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 8 | Bitmap read result, one cycle after the request |
| ack_req | input | 1 | Acknowledge request |
| ack_cpu | input | 3 | ID of the acknowledging processor |
| ack_sgi | input | $clog2(NSGI) | Interrupt being acknowledged |
| ack_done | output | 1 | Acknowledge response valid |
| ack_found | output | 1 | A requester was recorded |
| ack_src | output | 3 | Lowest recorded requester |
| pend | output | NCPU*NSGI | Pending flags, receiver-major |

## Verification
An acknowledge and a register write can hit the same pair in the same cycle. The acknowledge removes one requester bit, and the write may add or remove others. The bench provokes this with directed cycles. In the first, a byte set on the pair being acknowledged must keep it pending and merge both changes. In the second, a byte clear removes the last remaining bit, so the flag must drop. Several hundred random cycles then mix the two operations. The expected source and the resulting bitmap are taken from the state before the cycle, with clears applied before sets, and compared against the outputs.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int CPU_IDW  = 3;
    localparam int MAX_CPUS = 8;
    localparam int ADDR_W   = 12;

    localparam logic [ADDR_W-1:0] SEND_ADDR = 12'hF00;
    localparam logic [ADDR_W-1:0] DROP_BASE = 12'hF10;
    localparam logic [ADDR_W-1:0] RAISE_BASE = 12'hF20;

    localparam int ID_LSB     = 0;
    localparam int ID_W       = 10;
    localparam int LIST_LSB   = 16;
    localparam int FILTER_LSB = 24;

    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_BAD    = 2'd3
    } filter_e;

    // true when addr lies in [base, base+count)
    function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                       input logic [ADDR_W-1:0] base,
                                       input int count);
        logic [ADDR_W-1:0] off;
        off = addr - base;
        return (addr >= base) && (int'(off) < count);
    endfunction

endpackage

// File: rtl/sgi_cmd_decode.sv
module sgi_cmd_decode
    import sgi_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSGI = 16
) (
    input  logic                   wr_en,
    input  logic [CPU_IDW-1:0]     wr_cpu,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    output logic [NCPU*NSGI-1:0]   set_cells,
    output logic [NCPU-1:0]        set_bits,
    output logic [NCPU*NSGI-1:0]   clr_cells,
    output logic [NCPU-1:0]        clr_bits
);
    localparam int SGI_W = (NSGI > 1) ? $clog2(NSGI) : 1;

    logic                  writer_ok;
    logic [NCPU-1:0]       writer_oh;
    logic                  is_send;
    logic                  is_raise;
    logic                  is_drop;
    logic [SGI_W-1:0]      send_id;
    logic [SGI_W-1:0]      byte_id;
    logic [NCPU-1:0]       targets;
    filter_e               filt;
    logic [ADDR_W-1:0]     raise_off;
    logic [ADDR_W-1:0]     drop_off;

    always_comb begin
        writer_ok = int'(wr_cpu) < NCPU;
        writer_oh = writer_ok ? (NCPU'(1) << wr_cpu) : '0;
        is_send   = wr_en && writer_ok && (wr_addr == SEND_ADDR)
                    && (int'(wr_data[ID_LSB +: ID_W]) < NSGI);
        is_raise  = wr_en && writer_ok && in_window(wr_addr, RAISE_BASE, NSGI);
        is_drop   = wr_en && writer_ok && in_window(wr_addr, DROP_BASE, NSGI);
        send_id   = wr_data[ID_LSB +: SGI_W];
        raise_off = wr_addr - RAISE_BASE;
        drop_off  = wr_addr - DROP_BASE;
        byte_id   = is_raise ? raise_off[SGI_W-1:0] : drop_off[SGI_W-1:0];
        filt      = filter_e'(wr_data[FILTER_LSB +: 2]);

        unique case (filt)
            FLT_LIST:   targets = wr_data[LIST_LSB +: NCPU];
            FLT_OTHERS: targets = ~writer_oh;
            FLT_SELF:   targets = writer_oh;
            default:    targets = '1;
        endcase

        set_bits = is_send ? writer_oh : wr_data[NCPU-1:0];
        clr_bits = wr_data[NCPU-1:0];
    end

    for (genvar t = 0; t < NCPU; t++) begin : g_tgt
        for (genvar s = 0; s < NSGI; s++) begin : g_sgi
            localparam int CELL = t * NSGI + s;
            assign set_cells[CELL] =
                (is_send && (send_id == SGI_W'(s)) && targets[t]) ||
                (is_raise && (byte_id == SGI_W'(s)) && writer_oh[t]);
            assign clr_cells[CELL] =
                is_drop && (byte_id == SGI_W'(s)) && writer_oh[t];
        end
    end

endmodule

// File: rtl/sgi_src_pick.sv
module sgi_src_pick
    import sgi_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]         vec,
    output logic                 found,
    output logic [CPU_IDW-1:0]   idx
);
    // scan downward so the lowest set bit is the last one kept
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = CPU_IDW'(i);
            end
        end
    end

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int NSGI = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_cpu,
    input  logic [11:0]                       wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic                              rd_en,
    input  logic [2:0]                        rd_cpu,
    input  logic [11:0]                       rd_addr,
    output logic [7:0]                        rd_data,
    input  logic                              ack_req,
    input  logic [2:0]                        ack_cpu,
    input  logic [$clog2(NSGI)-1:0]           ack_sgi,
    output logic                              ack_done,
    output logic                              ack_found,
    output logic [2:0]                        ack_src,
    output logic [NCPU*NSGI-1:0]              pend
);
    localparam int NCELL  = NCPU * NSGI;
    localparam int CELL_W = (NCELL > 1) ? $clog2(NCELL) : 1;
    localparam int SGI_W  = $clog2(NSGI);

    typedef struct packed {
        logic [NCELL-1:0][NCPU-1:0] bm;
        logic [NCELL-1:0]           pend;
        logic                       ack_done;
        logic                       ack_found;
        logic [CPU_IDW-1:0]         ack_src;
        logic [7:0]                 rd_data;
    } state_t;

    state_t state_d, state_q;

    logic [NCELL-1:0]     set_cells, clr_cells;
    logic [NCPU-1:0]      set_bits, clr_bits;
    logic                 ack_ok;
    logic [CELL_W-1:0]    ack_cell;
    logic [NCPU-1:0]      ack_vec;
    logic                 pick_found;
    logic [CPU_IDW-1:0]   pick_idx;
    logic [NCPU-1:0]      ack_clr;
    logic                 rd_ok;
    logic [CELL_W-1:0]    rd_cell;
    logic [ADDR_W-1:0]    rd_off;

    sgi_cmd_decode #(.NCPU(NCPU), .NSGI(NSGI)) u_decode (
        .wr_en     (wr_en),
        .wr_cpu    (wr_cpu),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .set_cells (set_cells),
        .set_bits  (set_bits),
        .clr_cells (clr_cells),
        .clr_bits  (clr_bits)
    );

    sgi_src_pick #(.W(NCPU)) u_pick (
        .vec   (ack_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // acknowledge and read addressing
    always_comb begin
        ack_ok   = ack_req && (int'(ack_cpu) < NCPU);
        ack_cell = CELL_W'(int'(ack_cpu) * NSGI + int'(ack_sgi));
        ack_vec  = ack_ok ? state_q.bm[ack_cell] : '0;
        ack_clr  = pick_found ? (NCPU'(1) << pick_idx) : '0;

        rd_off = in_window(rd_addr, DROP_BASE, NSGI) ? (rd_addr - DROP_BASE)
                                                     : (rd_addr - RAISE_BASE);
        rd_ok  = rd_en && (int'(rd_cpu) < NCPU) &&
                 (in_window(rd_addr, DROP_BASE, NSGI) ||
                  in_window(rd_addr, RAISE_BASE, NSGI));
        rd_cell = CELL_W'(int'(rd_cpu) * NSGI + int'(rd_off[SGI_W-1:0]));
    end

    always_comb begin
        logic [NCPU-1:0] nb;
        logic            ak;
        state_d = state_q;

        state_d.ack_done  = ack_ok;
        state_d.ack_found = ack_ok && pick_found;
        state_d.ack_src   = (ack_ok && pick_found) ? pick_idx : '0;
        state_d.rd_data   = rd_ok ? 8'(state_q.bm[rd_cell]) : 8'h00;

        for (int c = 0; c < NCELL; c++) begin
            ak = ack_ok && (ack_cell == CELL_W'(c));
            nb = state_q.bm[c];
            if (ak)           nb = nb & ~ack_clr;
            if (clr_cells[c]) nb = nb & ~clr_bits;
            if (set_cells[c]) nb = nb | set_bits;
            state_d.bm[c] = nb;
            if (set_cells[c]) begin
                state_d.pend[c] = 1'b1;
            end else if ((ak || clr_cells[c]) && (nb == '0)) begin
                state_d.pend[c] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend      = state_q.pend;
    assign ack_done  = state_q.ack_done;
    assign ack_found = state_q.ack_found;
    assign ack_src   = state_q.ack_src;
    assign rd_data   = state_q.rd_data;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
    parameter int NCPU = 4,
    parameter int NSGI = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    ack_req,
    input logic [2:0]              ack_cpu,
    input logic [$clog2(NSGI)-1:0] ack_sgi,
    input logic                    ack_done,
    input logic                    ack_found,
    input logic [2:0]              ack_src,
    input logic [NCPU*NSGI-1:0]    pend
);
    localparam int NCELL = NCPU * NSGI;

    logic [NCELL-1:0] pend_prev;
    logic             wr_prev;
    logic             ack_prev;
    logic             ack_valid_prev;
    int               cell_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_prev      <= '0;
            wr_prev        <= 1'b0;
            ack_prev       <= 1'b0;
            ack_valid_prev <= 1'b0;
            cell_prev      <= 0;
        end else begin
            pend_prev      <= pend;
            wr_prev        <= wr_en;
            ack_prev       <= ack_req;
            ack_valid_prev <= ack_req && (int'(ack_cpu) < NCPU);
            cell_prev      <= int'(ack_cpu) * NSGI + int'(ack_sgi);
        end
    end

    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && int'(ack_cpu) < NCPU) |=> ack_done); // R8

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |-> ack_valid_prev); // R8

    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_found) |-> (int'(ack_src) < NCPU)); // R8

    AST_FOUND_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_found) |-> (cell_prev < NCELL && pend_prev[cell_prev])); // R9

    AST_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~pend_prev) != '0) |-> wr_prev); // R5

    AST_FALL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend & pend_prev) != '0) |-> (wr_prev || ack_prev)); // R9

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCPU(NCPU), .NSGI(NSGI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .ack_req   (ack_req),
    .ack_cpu   (ack_cpu),
    .ack_sgi   (ack_sgi),
    .ack_done  (ack_done),
    .ack_found (ack_found),
    .ack_src   (ack_src),
    .pend      (pend)
);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
    localparam int NCPU = 4;
    localparam int NSGI = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_cpu;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [2:0]  rd_cpu;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic        ack_req;
    logic [2:0]  ack_cpu;
    logic [3:0]  ack_sgi;
    logic        ack_done;
    logic        ack_found;
    logic [2:0]  ack_src;
    logic [63:0] pend;

    always #5 clk = ~clk;

    sgi_dispatch #(.NCPU(NCPU), .NSGI(NSGI)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_cpu(rd_cpu),
        .rd_addr(rd_addr), .rd_data(rd_data), .ack_req(ack_req),
        .ack_cpu(ack_cpu), .ack_sgi(ack_sgi), .ack_done(ack_done),
        .ack_found(ack_found), .ack_src(ack_src), .pend(pend)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [3:0] mbm   [NSGI][NCPU];
    bit         mpend [NSGI][NCPU];
    int         exp_q [$];
    string      tag_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_pend();
        logic [63:0] v = '0;
        for (int t = 0; t < NCPU; t++)
            for (int s = 0; s < NSGI; s++)
                v[t*NSGI+s] = mpend[s][t];
        return v;
    endfunction

    // scoreboard monitor for acknowledge responses
    always @(negedge clk) begin
        if (rst_n && ack_done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected ack response", {ack_found, ack_src}, 0);
            end else begin
                int    e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk({ack_found, ack_src} == e[3:0], tg, "ack found/src",
                    {ack_found, ack_src}, e[3:0]);
            end
        end
    end

    // one cycle: optional write and optional acknowledge; starts and ends at negedge
    task automatic step(input bit wen, input int wcpu, input int waddr,
                        input logic [31:0] wdata, input bit aen, input int acpu,
                        input int asgi, input string req);
        logic [3:0] setb  [NSGI][NCPU];
        logic [3:0] clrb  [NSGI][NCPU];
        bit         sflag [NSGI][NCPU];
        bit         touch [NSGI][NCPU];
        for (int s = 0; s < NSGI; s++)
            for (int t = 0; t < NCPU; t++) begin
                setb[s][t] = '0; clrb[s][t] = '0; sflag[s][t] = 0; touch[s][t] = 0;
            end
        wr_en = wen; wr_cpu = 3'(wcpu); wr_addr = 12'(waddr); wr_data = wdata;
        ack_req = aen; ack_cpu = 3'(acpu); ack_sgi = 4'(asgi);

        if (aen && acpu < NCPU) begin
            logic [3:0] v;
            int src;
            v = mbm[asgi][acpu];
            src = 0;
            for (int i = NCPU - 1; i >= 0; i--) if (v[i]) src = i;
            exp_q.push_back((v != 0) ? (8 + src) : 0);
            tag_q.push_back(req);
            if (v != 0) clrb[asgi][acpu] = 4'(1 << src);
            touch[asgi][acpu] = 1;
        end

        if (wen && wcpu < NCPU) begin
            if (waddr == 'hF00 && wdata[9:0] < NSGI) begin
                logic [3:0] tg;
                case (wdata[25:24])
                    2'd0: tg = wdata[19:16];
                    2'd1: tg = 4'hF & ~4'(1 << wcpu);
                    2'd2: tg = 4'(1 << wcpu);
                    default: tg = 4'hF;
                endcase
                for (int t = 0; t < NCPU; t++) if (tg[t]) begin
                    setb[wdata[3:0]][t] |= 4'(1 << wcpu);
                    sflag[wdata[3:0]][t] = 1;
                end
            end else if (waddr >= 'hF10 && waddr <= 'hF1F) begin
                clrb[waddr - 'hF10][wcpu] |= wdata[3:0];
                touch[waddr - 'hF10][wcpu] = 1;
            end else if (waddr >= 'hF20 && waddr <= 'hF2F) begin
                setb[waddr - 'hF20][wcpu] |= wdata[3:0];
                sflag[waddr - 'hF20][wcpu] = 1;
            end
        end

        for (int s = 0; s < NSGI; s++)
            for (int t = 0; t < NCPU; t++) begin
                logic [3:0] nb;
                nb = (mbm[s][t] & ~clrb[s][t]) | setb[s][t];
                mbm[s][t] = nb;
                if (sflag[s][t]) mpend[s][t] = 1;
                else if (touch[s][t] && nb == 0) mpend[s][t] = 0;
            end

        @(negedge clk);
        wr_en = 0; ack_req = 0;
        chk(pend == model_pend(), req, "pend vector (R11 layout)", pend, model_pend());
    endtask

    task automatic rd(input int cpu, input int addr, input string req);
        logic [7:0] e;
        e = 8'h00;
        if (cpu < NCPU && addr >= 'hF10 && addr <= 'hF2F)
            e = {4'h0, mbm[addr & 'hF][cpu]};
        rd_en = 1; rd_cpu = 3'(cpu); rd_addr = 12'(addr);
        @(negedge clk);
        rd_en = 0;
        chk(rd_data == e, req, "read bitmap", rd_data, e);
    endtask

    function automatic logic [31:0] send(input int id, input int filt, input int list);
        return {6'h0, 2'(filt), 8'(list), 6'h0, 10'(id)};
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NSGI; s++)
            for (int t = 0; t < NCPU; t++) begin mbm[s][t] = 0; mpend[s][t] = 0; end
        rst_n = 0; wr_en = 0; wr_cpu = 0; wr_addr = 0; wr_data = 0;
        rd_en = 0; rd_cpu = 0; rd_addr = 0; ack_req = 0; ack_cpu = 0; ack_sgi = 0;
        repeat (3) @(negedge clk);
        chk(pend == 0, "R1", "pend in reset", pend, 0);
        rst_n = 1;
        @(negedge clk);
        chk(pend == 0 && ack_done == 0 && rd_data == 0, "R1", "state after reset",
            {pend, ack_done}, 0);

        // R2: filter 0, writer 1 to receivers 0 and 2, interrupt 3
        step(1, 1, 'hF00, send(3, 0, 'b0101), 0, 0, 0, "R2");
        rd(0, 'hF23, "R7");
        rd(2, 'hF13, "R7");
        rd(1, 'hF23, "R7");
        // R3: other filters
        step(1, 2, 'hF00, send(5, 1, 0), 0, 0, 0, "R3");
        step(1, 3, 'hF00, send(7, 2, 'hFF), 0, 0, 0, "R3");
        step(1, 0, 'hF00, send(9, 3, 0), 0, 0, 0, "R3");
        rd(3, 'hF29, "R3");
        // R4: ignored writes
        step(1, 1, 'hF00, send(16, 3, 0), 0, 0, 0, "R4");
        step(1, 1, 'hF00, send('h3FF, 3, 0), 0, 0, 0, "R4");
        step(1, 5, 'hF00, send(1, 3, 0), 0, 0, 0, "R4");
        step(1, 6, 'hF21, 32'hF, 0, 0, 0, "R4");
        step(1, 0, 'hF00, send(12, 0, 'hF0), 0, 0, 0, "R4");
        // R5: byte set, including zero data
        step(1, 0, 'hF24, 32'h0A, 0, 0, 0, "R5");
        step(1, 1, 'hF2B, 32'h00, 0, 0, 0, "R5");
        rd(0, 'hF14, "R5");
        // R8/R9: acknowledge order and pending drop
        step(0, 0, 0, 0, 1, 0, 4, "R8");
        step(0, 0, 0, 0, 1, 0, 4, "R9");
        step(0, 0, 0, 0, 1, 1, 11, "R9");
        step(0, 0, 0, 0, 1, 6, 4, "R8");
        // R6: byte clear
        step(1, 1, 'hF00, send(6, 0, 'b0100), 0, 0, 0, "R6");
        step(1, 3, 'hF00, send(6, 0, 'b0100), 0, 0, 0, "R6");
        step(1, 2, 'hF16, 32'h02, 0, 0, 0, "R6");
        step(1, 2, 'hF16, 32'h08, 0, 0, 0, "R6");
        // R10: same-cycle ack and write on one pair
        step(1, 0, 'hF22, 32'h06, 0, 0, 0, "R10");
        step(1, 0, 'hF22, 32'h01, 1, 0, 2, "R10");
        rd(0, 'hF22, "R10");
        step(1, 0, 'hF12, 32'h04, 1, 0, 2, "R10");
        // R7: out-of-window and bad requester
        rd(0, 'hF30, "R7");
        rd(5, 'hF23, "R7");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int kind, a;
            logic [31:0] d;
            kind = $urandom_range(0, 3);
            d = $urandom;
            case (kind)
                0: begin a = 'hF00; d = send($urandom_range(0, 19), $urandom_range(0, 3), $urandom_range(0, 255)); end
                1: a = 'hF10 + $urandom_range(0, 15);
                2: a = 'hF20 + $urandom_range(0, 15);
                default: a = 'hF30 + $urandom_range(0, 3);
            endcase
            step($urandom_range(0, 1), $urandom_range(0, 4), a, d,
                 $urandom_range(0, 1), $urandom_range(0, 4), $urandom_range(0, 15), "R10");
        end
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "missing ack responses", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule